// File: doc/BRIEF.md
# Static-Memory Region Controller

This block turns single read or write requests from an on-chip bus into strobed accesses on a shared asynchronous memory bus. Each request carries a 28-bit byte address. The two top address bits choose one of four 64 MB regions, and each region has its own active-low select line. The regions share the address, data, output-enable and write-enable lines, so only one external access is in progress at any time. A requester presents a request, waits for `req_ready`, and then gets a single-cycle response that carries read data or an error flag.

Each region has three registers, written through a small configuration port: a control word and two timing words, one for reads and one for writes. The control word holds the enable, the write permission, the bus width, the memory type and an extended-timing bit. Each timing word holds an address-setup count, a data-phase count and an access-mode code. A region set to 16 bits drops internal address bit 0 before driving the external address. A display controller can then tie its register-select pin to external address bit 0 and use two neighbouring half-word addresses, one for commands and one for data.

Top module: `smc_region_ctrl`

## Requirements
- R1: Request address bits [27:26] give the region index n, and during the access only `mem_cs_n[n]` is low. At most one select line is low at any time.
- R2: The external address is request bits [25:1] for a 16-bit region (width code 01) and bits [25:0] for an 8-bit region (width code 00). An 8-bit region returns read data in bits [7:0] with bits [15:8] zero, and drives write data with bits [15:8] zero.
- R3: After the select line falls, both strobes stay high for ADDSET cycles (timing word bits [3:0], 0 to 15). The active strobe then stays low for DATAST cycles (timing word bits [11:4], up to 255). The two strobes are never low together.
- R4: A DATAST value of 0 gives a one-cycle data phase.
- R5: When the control word's extended bit (bit 6) is 0, writes use the read timing word. When it is 1, writes use the write timing word.
- R6: Read data is captured on the last data-phase cycle. The strobe rises while the select line is still low. One cycle later the select line rises, and `resp_valid` pulses in that same cycle.
- R7: An access to a region whose enable bit (control bit 0) is clear drives no select line and gets `resp_err` one cycle after it is accepted.
- R8: A write to a region whose write-permission bit (control bit 1) is clear never pulls `mem_we_n` low and returns an error. Reads from that region still work.
- R9: A reserved width code (10, 11), a reserved memory-type code (control bits [5:4] = 11), or a selected timing word whose access-mode field (bits [13:12]) is not 00 makes the access fail with an error.
- R10: `req_ready` is low from the cycle after an access starts until its response. A strobe is only ever low while a select line is low.
- R11: During a write, `mem_dq_oe` is high while the write strobe is low. During a read, `mem_dq_oe` stays low.
- R12: After reset, all select lines and strobes are high, no response is pending, every region is disabled, and every timing word holds ADDSET 15 and DATAST 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_region | input | 2 | Region whose register is written |
| cfg_sel | input | 2 | Register select: 0 control, 1 read timing, 2 write timing |
| cfg_wdata | input | 14 | Configuration word |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 28 | Byte address |
| req_wdata | input | 16 | Write data |
| resp_valid | output | 1 | One-cycle response pulse |
| resp_err | output | 1 | Response is an error |
| resp_rdata | output | 16 | Read data |
| mem_cs_n | output | 4 | Per-region select, active low |
| mem_oe_n | output | 1 | Read strobe, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_addr | output | 26 | External address |
| mem_dq_o | output | 16 | Data toward memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_o |
| mem_dq_i | input | 16 | Data from memory |

## Verification
The bench builds the block with its default parameters: a 28-bit address, a 16-bit data bus and four regions, so the one-hot select check covers a full two-bit region index. The four regions are set up differently: one 16-bit region with separate write timing, one 8-bit region that shares timing and has a zero data phase, one read-only region and one disabled region. This brings the setup and data counts 0, 1, 15 and 255, both width shifts and every error cause within reach. The bench's memory model returns data derived from the external address, so each read result also confirms the address shift.

// File: rtl/smc_pkg.sv
package smc_pkg;

    localparam int CFG_W = 14;

    localparam logic [1:0] WIDTH_8   = 2'b00;
    localparam logic [1:0] WIDTH_16  = 2'b01;
    localparam logic [1:0] MTYPE_BAD = 2'b11;
    localparam logic [1:0] MODE_A    = 2'b00;

    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_RTIM = 2'd1;
    localparam logic [1:0] SEL_WTIM = 2'd2;

    // control word, bit 0 at the bottom
    typedef struct packed {
        logic       ext;
        logic [1:0] mtype;
        logic [1:0] width;
        logic       wr_ok;
        logic       en;
    } ctrl_t;

    // timing word: [13:12] mode, [11:4] data phase, [3:0] setup
    typedef struct packed {
        logic [1:0] mode;
        logic [7:0] datast;
        logic [3:0] addset;
    } tim_t;

    localparam ctrl_t CTRL_RST = '{ext: 1'b0, mtype: 2'b00, width: 2'b00, wr_ok: 1'b0, en: 1'b0};
    localparam tim_t  TIM_RST  = '{mode: MODE_A, datast: 8'hFF, addset: 4'hF};

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_DATA,
        ST_HOLD
    } seq_st_e;

endpackage

// File: rtl/smc_cfg_regs.sv
module smc_cfg_regs
    import smc_pkg::*;
#(
    parameter int REGIONS = 4,
    localparam int SEL_W  = $clog2(REGIONS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [SEL_W-1:0] cfg_region,
    input  logic [1:0]       cfg_sel,
    input  logic [CFG_W-1:0] cfg_wdata,
    output ctrl_t            ctrl_o [REGIONS],
    output tim_t             rtim_o [REGIONS],
    output tim_t             wtim_o [REGIONS]
);

    typedef struct packed {
        ctrl_t c;
        tim_t  r;
        tim_t  w;
    } region_cfg_t;

    for (genvar g = 0; g < REGIONS; g++) begin : g_region
        region_cfg_t cfg_d, cfg_q;

        always_comb begin
            cfg_d = cfg_q;
            if (cfg_we && (cfg_region == SEL_W'(g))) begin
                case (cfg_sel)
                    SEL_CTRL: cfg_d.c = ctrl_t'(cfg_wdata[$bits(ctrl_t)-1:0]);
                    SEL_RTIM: cfg_d.r = tim_t'(cfg_wdata);
                    SEL_WTIM: cfg_d.w = tim_t'(cfg_wdata);
                    default:  cfg_d   = cfg_q;
                endcase
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg_q <= '{c: CTRL_RST, r: TIM_RST, w: TIM_RST};
            end else begin
                cfg_q <= cfg_d;
            end
        end

        assign ctrl_o[g] = cfg_q.c;
        assign rtim_o[g] = cfg_q.r;
        assign wtim_o[g] = cfg_q.w;
    end

endmodule

// File: rtl/smc_addr_map.sv
module smc_addr_map
    import smc_pkg::*;
#(
    parameter int ADDR_W  = 28,
    parameter int REGIONS = 4,
    localparam int SEL_W  = $clog2(REGIONS),
    localparam int EXT_W  = ADDR_W - SEL_W
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        width_i,
    output logic [SEL_W-1:0]  region_o,
    output logic [EXT_W-1:0]  ext_addr_o
);

    assign region_o = addr_i[ADDR_W-1 -: SEL_W];

    always_comb begin
        if (width_i == WIDTH_16) begin
            ext_addr_o = {1'b0, addr_i[EXT_W-1:1]};
        end else begin
            ext_addr_o = addr_i[EXT_W-1:0];
        end
    end

endmodule

// File: rtl/smc_seq.sv
module smc_seq
    import smc_pkg::*;
#(
    parameter int REGIONS = 4,
    parameter int EXT_W   = 26,
    parameter int DATA_W  = 16,
    localparam int SEL_W  = $clog2(REGIONS),
    localparam int HALF_W = DATA_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              err_i,
    input  logic              wr_i,
    input  logic              narrow_i,
    input  logic [SEL_W-1:0]  region_i,
    input  logic [EXT_W-1:0]  ext_addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [3:0]        addset_i,
    input  logic [7:0]        datast_i,
    input  logic [DATA_W-1:0] mem_dq_i,
    output logic              busy_o,
    output logic [REGIONS-1:0] cs_n_o,
    output logic              oe_n_o,
    output logic              we_n_o,
    output logic [EXT_W-1:0]  addr_o,
    output logic [DATA_W-1:0] dq_o,
    output logic              dq_oe_o,
    output logic              resp_valid_o,
    output logic              resp_err_o,
    output logic [DATA_W-1:0] resp_rdata_o
);

    typedef struct packed {
        seq_st_e             st;
        logic [7:0]          cnt;
        logic [7:0]          dat;
        logic                wr;
        logic                narrow;
        logic [REGIONS-1:0]  cs_n;
        logic                oe_n;
        logic                we_n;
        logic [EXT_W-1:0]    addr;
        logic [DATA_W-1:0]   dq;
        logic                dq_oe;
        logic                resp_valid;
        logic                resp_err;
        logic [DATA_W-1:0]   rdata;
    } seq_t;

    seq_t s_d, s_q;

    function automatic logic [DATA_W-1:0] trim(input logic nar, input logic [DATA_W-1:0] v);
        if (nar) return {{(DATA_W-HALF_W){1'b0}}, v[HALF_W-1:0]};
        return v;
    endfunction

    always_comb begin
        logic [7:0] dat_eff;
        dat_eff = (datast_i == 8'd0) ? 8'd1 : datast_i;
        s_d = s_q;
        s_d.resp_valid = 1'b0;
        s_d.resp_err   = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    s_d.wr     = wr_i;
                    s_d.narrow = narrow_i;
                    s_d.addr   = ext_addr_i;
                    s_d.dq     = trim(narrow_i, wdata_i);
                    s_d.dq_oe  = wr_i;
                    s_d.cs_n   = ~(REGIONS'(1) << region_i);
                    s_d.dat    = dat_eff;
                    if (addset_i != 4'd0) begin
                        s_d.st  = ST_SETUP;
                        s_d.cnt = {4'd0, addset_i} - 8'd1;
                    end else begin
                        s_d.st   = ST_DATA;
                        s_d.cnt  = dat_eff - 8'd1;
                        s_d.oe_n = wr_i;
                        s_d.we_n = !wr_i;
                    end
                end else if (err_i) begin
                    s_d.resp_valid = 1'b1;
                    s_d.resp_err   = 1'b1;
                    s_d.rdata      = '0;
                end
            end
            ST_SETUP: begin
                if (s_q.cnt == 8'd0) begin
                    s_d.st   = ST_DATA;
                    s_d.cnt  = s_q.dat - 8'd1;
                    s_d.oe_n = s_q.wr;
                    s_d.we_n = !s_q.wr;
                end else begin
                    s_d.cnt = s_q.cnt - 8'd1;
                end
            end
            ST_DATA: begin
                if (s_q.cnt == 8'd0) begin
                    s_d.st    = ST_HOLD;
                    s_d.oe_n  = 1'b1;
                    s_d.we_n  = 1'b1;
                    s_d.rdata = s_q.wr ? '0 : trim(s_q.narrow, mem_dq_i);
                end else begin
                    s_d.cnt = s_q.cnt - 8'd1;
                end
            end
            ST_HOLD: begin
                s_d.st         = ST_IDLE;
                s_d.cs_n       = '1;
                s_d.dq_oe      = 1'b0;
                s_d.resp_valid = 1'b1;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, cs_n: '1, oe_n: 1'b1, we_n: 1'b1, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o       = (s_q.st != ST_IDLE);
    assign cs_n_o       = s_q.cs_n;
    assign oe_n_o       = s_q.oe_n;
    assign we_n_o       = s_q.we_n;
    assign addr_o       = s_q.addr;
    assign dq_o         = s_q.dq;
    assign dq_oe_o      = s_q.dq_oe;
    assign resp_valid_o = s_q.resp_valid;
    assign resp_err_o   = s_q.resp_err;
    assign resp_rdata_o = s_q.rdata;

endmodule

// File: rtl/smc_region_ctrl.sv
module smc_region_ctrl
    import smc_pkg::*;
#(
    parameter int ADDR_W  = 28,
    parameter int DATA_W  = 16,
    parameter int REGIONS = 4,
    localparam int SEL_W  = $clog2(REGIONS),
    localparam int EXT_W  = ADDR_W - SEL_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [SEL_W-1:0]   cfg_region,
    input  logic [1:0]         cfg_sel,
    input  logic [CFG_W-1:0]   cfg_wdata,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               resp_valid,
    output logic               resp_err,
    output logic [DATA_W-1:0]  resp_rdata,
    output logic [REGIONS-1:0] mem_cs_n,
    output logic               mem_oe_n,
    output logic               mem_we_n,
    output logic [EXT_W-1:0]   mem_addr,
    output logic [DATA_W-1:0]  mem_dq_o,
    output logic               mem_dq_oe,
    input  logic [DATA_W-1:0]  mem_dq_i
);

    ctrl_t ctrl_w [REGIONS];
    tim_t  rtim_w [REGIONS];
    tim_t  wtim_w [REGIONS];

    logic [SEL_W-1:0] region;
    logic [EXT_W-1:0] ext_addr;
    ctrl_t            cur_ctrl;
    tim_t             cur_tim;
    logic             access_ok;
    logic             busy;

    smc_cfg_regs #(.REGIONS(REGIONS)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_region (cfg_region),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .ctrl_o     (ctrl_w),
        .rtim_o     (rtim_w),
        .wtim_o     (wtim_w)
    );

    assign region   = req_addr[ADDR_W-1 -: SEL_W];
    assign cur_ctrl = ctrl_w[region];
    assign cur_tim  = (req_write && cur_ctrl.ext) ? wtim_w[region] : rtim_w[region];

    smc_addr_map #(.ADDR_W(ADDR_W), .REGIONS(REGIONS)) u_map (
        .addr_i     (req_addr),
        .width_i    (cur_ctrl.width),
        .region_o   (),
        .ext_addr_o (ext_addr)
    );

    always_comb begin
        access_ok = cur_ctrl.en
                 && ((cur_ctrl.width == WIDTH_8) || (cur_ctrl.width == WIDTH_16))
                 && (cur_ctrl.mtype != MTYPE_BAD)
                 && (cur_tim.mode == MODE_A)
                 && !(req_write && !cur_ctrl.wr_ok);
    end

    assign req_ready = !busy;

    smc_seq #(.REGIONS(REGIONS), .EXT_W(EXT_W), .DATA_W(DATA_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (req_valid && req_ready && access_ok),
        .err_i        (req_valid && req_ready && !access_ok),
        .wr_i         (req_write),
        .narrow_i     (cur_ctrl.width == WIDTH_8),
        .region_i     (region),
        .ext_addr_i   (ext_addr),
        .wdata_i      (req_wdata),
        .addset_i     (cur_tim.addset),
        .datast_i     (cur_tim.datast),
        .mem_dq_i     (mem_dq_i),
        .busy_o       (busy),
        .cs_n_o       (mem_cs_n),
        .oe_n_o       (mem_oe_n),
        .we_n_o       (mem_we_n),
        .addr_o       (mem_addr),
        .dq_o         (mem_dq_o),
        .dq_oe_o      (mem_dq_oe),
        .resp_valid_o (resp_valid),
        .resp_err_o   (resp_err),
        .resp_rdata_o (resp_rdata)
    );

endmodule

// File: rtl/smc_region_ctrl_chk.sv
module smc_region_ctrl_chk #(
    parameter int REGIONS = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_ready,
    input logic [REGIONS-1:0] mem_cs_n,
    input logic               mem_oe_n,
    input logic               mem_we_n,
    input logic               mem_dq_oe,
    input logic               resp_valid,
    input logic               resp_err
);

    p_one_cs_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~mem_cs_n) <= 1);

    p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n));

    p_strobe_in_cs_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_oe_n || !mem_we_n) |-> !(&mem_cs_n));

    p_busy_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(&mem_cs_n) |-> !req_ready);

    p_resp_cs_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_err) |-> ((&mem_cs_n) && !$past(&mem_cs_n)));

    p_strobe_rise_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_oe_n) || $rose(mem_we_n)) |-> !(&mem_cs_n));

    p_err_no_cs_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_err) |-> ((&mem_cs_n) && $past(&mem_cs_n)));

    p_read_no_drive_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_dq_oe);

    p_write_drive_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_dq_oe);

endmodule

bind smc_region_ctrl smc_region_ctrl_chk #(.REGIONS(REGIONS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .mem_cs_n   (mem_cs_n),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_dq_oe  (mem_dq_oe),
    .resp_valid (resp_valid),
    .resp_err   (resp_err)
);

// File: tb/smc_region_ctrl_tb.sv
module smc_region_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_region = '0;
    logic [1:0]  cfg_sel = '0;
    logic [13:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [27:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        resp_valid, resp_err;
    logic [15:0] resp_rdata;
    logic [3:0]  mem_cs_n;
    logic        mem_oe_n, mem_we_n, mem_dq_oe;
    logic [25:0] mem_addr;
    logic [15:0] mem_dq_o, mem_dq_i;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit ended  = 1'b0;

    always #10 clk = ~clk;

    assign mem_dq_i = mem_addr[15:0] ^ 16'hA5C3;

    smc_region_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_region(cfg_region), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .resp_valid(resp_valid), .resp_err(resp_err), .resp_rdata(resp_rdata),
        .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_addr(mem_addr), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
            finish_run();
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic cfg(input logic [1:0] rg, input logic [1:0] sel, input logic [13:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_region = rg; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    typedef struct {
        int          setup, dataph, hold, bad_strobe, ready_high;
        logic        err;
        logic [15:0] rd, dq;
        logic        dq_oe;
        logic [25:0] ea;
        logic [3:0]  cs;
    } obs_t;

    task automatic access(input logic wr, input logic [27:0] a, input logic [15:0] wd,
                          output obs_t o);
        bit done = 1'b0;
        bit strobe_seen = 1'b0;
        int k = 0;
        o = '{setup: 0, dataph: 0, hold: 0, bad_strobe: 0, ready_high: 0,
              err: 1'b0, rd: '0, dq: '0, dq_oe: 1'b0, ea: '0, cs: 4'hF};
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (!done && k < 700) begin
            if (resp_valid) begin
                o.err = resp_err;
                o.rd  = resp_rdata;
                done  = 1'b1;
            end else begin
                if (mem_cs_n != 4'hF) begin
                    o.cs = mem_cs_n;
                    o.ea = mem_addr;
                    if (req_ready) o.ready_high++;
                    if (!mem_oe_n || !mem_we_n) begin
                        strobe_seen = 1'b1;
                        o.dataph++;
                        if (!mem_we_n) begin
                            o.dq = mem_dq_o;
                            o.dq_oe = mem_dq_oe;
                        end
                        if ((!mem_we_n && !wr) || (!mem_oe_n && wr)) o.bad_strobe++;
                    end else if (!strobe_seen) begin
                        o.setup++;
                    end else begin
                        o.hold++;
                    end
                end else if (!mem_we_n || !mem_oe_n) begin
                    o.bad_strobe++;
                end
                k++;
                @(negedge clk);
            end
        end
        chk(done, "R10", "response arrived", done, 1);
    endtask

    // {write, addr, wdata, expect_err, narrow, setup, data}
    localparam int VW = 1 + 28 + 16 + 1 + 1 + 4 + 8;
    localparam logic [VW-1:0] VECS [0:8] = '{
        {1'b0, 28'h0001234, 16'h0000, 1'b0, 1'b0, 4'd2, 8'd5},
        {1'b1, 28'h0000042, 16'hBEEF, 1'b0, 1'b0, 4'd1, 8'd2},
        {1'b0, 28'h4000033, 16'h0000, 1'b0, 1'b1, 4'd0, 8'd1},
        {1'b1, 28'h4000101, 16'h12A7, 1'b0, 1'b1, 4'd0, 8'd1},
        {1'b0, 28'h8000010, 16'h0000, 1'b0, 1'b0, 4'd3, 8'd4},
        {1'b1, 28'h8000010, 16'h5555, 1'b1, 1'b0, 4'd0, 8'd0},
        {1'b0, 28'hC000000, 16'h0000, 1'b1, 1'b0, 4'd0, 8'd0},
        {1'b1, 28'hC000004, 16'h0001, 1'b1, 1'b0, 4'd0, 8'd0},
        {1'b0, 28'h3FFFFFF, 16'h0000, 1'b0, 1'b0, 4'd2, 8'd5}
    };

    task automatic run_check(input logic wr, input logic [27:0] a, input logic [15:0] wd,
                             input logic exp_err, input logic nar,
                             input int exp_setup, input int exp_data);
        obs_t o;
        logic [25:0] exp_ea;
        logic [15:0] exp_rd, exp_dq;
        logic [3:0]  exp_cs;
        access(wr, a, wd, o);
        exp_ea = nar ? a[25:0] : {1'b0, a[25:1]};
        exp_cs = ~(4'b0001 << a[27:26]);
        exp_rd = exp_ea[15:0] ^ 16'hA5C3;
        if (nar) exp_rd = {8'h00, exp_rd[7:0]};
        exp_dq = nar ? {8'h00, wd[7:0]} : wd;
        chk(o.err == exp_err, "R9", "error flag", o.err, exp_err);
        if (exp_err) begin
            chk(o.cs == 4'hF, "R7", "select untouched on error", o.cs, 4'hF);
            chk(o.bad_strobe == 0 && o.dataph == 0, "R8", "no strobe on error", o.dataph, 0);
        end else begin
            chk(o.cs == exp_cs, "R1", "select line", o.cs, exp_cs);
            chk(o.ea == exp_ea, "R2", "external address", o.ea, exp_ea);
            chk(o.setup == exp_setup, "R3", "setup cycles", o.setup, exp_setup);
            chk(o.dataph == exp_data, "R4", "data cycles", o.dataph, exp_data);
            chk(o.hold == 1, "R6", "cycles between strobe rise and select rise", o.hold, 1);
            chk(o.bad_strobe == 0, "R11", "strobe matches direction", o.bad_strobe, 0);
            chk(o.ready_high == 0, "R10", "ready low while busy", o.ready_high, 0);
            if (wr) begin
                chk(o.dq == exp_dq, "R2", "write data", o.dq, exp_dq);
                chk(o.dq_oe, "R11", "data driven on write", o.dq_oe, 1);
            end else begin
                chk(o.rd == exp_rd, "R6", "read data", o.rd, exp_rd);
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        chk(mem_cs_n == 4'hF, "R12", "select lines in reset", mem_cs_n, 4'hF);
        chk(mem_oe_n && mem_we_n, "R12", "strobes in reset", {mem_oe_n, mem_we_n}, 3);
        chk(!resp_valid, "R12", "no response in reset", resp_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready, "R12", "ready after reset", req_ready, 1);

        // region 0: 16-bit, writable, extended timing
        cfg(2'd0, 2'd0, 14'h0047);
        cfg(2'd0, 2'd1, 14'h0052);
        cfg(2'd0, 2'd2, 14'h0021);
        // region 1: 8-bit, writable, shared timing, zero data phase (R5, R4)
        cfg(2'd1, 2'd0, 14'h0003);
        cfg(2'd1, 2'd1, 14'h0000);
        cfg(2'd1, 2'd2, 14'h0097);
        // region 2: 16-bit, NOR type, read-only (R8)
        cfg(2'd2, 2'd0, 14'h0025);
        cfg(2'd2, 2'd1, 14'h0043);
        // region 3 stays disabled (R7)

        for (int i = 0; i < 9; i++) begin
            logic [VW-1:0] v;
            v = VECS[i];
            run_check(v[58], v[57:30], v[29:14], v[13], v[12], int'(v[11:8]), int'(v[7:0]));
        end

        // R12: region 3 enabled with its reset timing, 15 setup and 255 data cycles
        cfg(2'd3, 2'd0, 14'h0007);
        run_check(1'b0, 28'hC000100, 16'h0, 1'b0, 1'b0, 15, 255);
        // R9: reserved width
        cfg(2'd3, 2'd0, 14'h000B);
        run_check(1'b0, 28'hC000100, 16'h0, 1'b1, 1'b0, 0, 0);
        // R9: reserved memory type
        cfg(2'd3, 2'd0, 14'h0037);
        run_check(1'b0, 28'hC000100, 16'h0, 1'b1, 1'b0, 0, 0);
        // R9: non-A access mode in the selected timing word
        cfg(2'd3, 2'd0, 14'h0007);
        cfg(2'd3, 2'd1, 14'h1031);
        run_check(1'b0, 28'hC000100, 16'h0, 1'b1, 1'b0, 0, 0);
        run_check(1'b1, 28'hC000100, 16'h77, 1'b1, 1'b0, 0, 0);
        // R5: same region, mode A restored, write follows new read timing
        cfg(2'd3, 2'd1, 14'h0031);
        run_check(1'b1, 28'hC000100, 16'h77, 1'b0, 1'b0, 1, 3);

        finish_run();
    end

endmodule